// File: doc/BRIEF.md
# Packed Bit-Manipulation Execute Stage

This block is one execute-stage slot of a 32-bit processor datapath that carries six bit-manipulation operations on packed data. These are a halfword bit reversal, a bit-field insert whose placement is read from a DSP control word, and four replicate operations. The replicates copy a byte or a halfword, taken from either the instruction immediate or from the rt operand, across the whole 32-bit word.

The issue logic presents an operation with a one-cycle valid strobe. Each presentation carries a 5-bit minor code, the rs and rt operand values, instruction bits 25:16 as a 10-bit immediate, the destination register index and the current DSP control word. One clock later the unit returns the result with a write enable, or it raises a reserved-instruction flag when the code is not recognised. Writes to register 0 are dropped.

Top module: `bitmanip_exec`

## Requirements
- R1: A synchronous active-high reset clears `res_data`, `res_we` and `res_illegal` to zero.
- R2: Code 0x1B (reverse) returns bits 15:0 of rt in reverse order: rt bit 0 goes to result bit 15 and rt bit 15 goes to result bit 0. Result bits 31:16 are zero.
- R3: Code 0x0C (insert) reads the size from control bits 11:7 and the position from control bits 4:0. When the field is valid, the result bits under the mask ((1<<size)-1)<<pos are the low `size` bits of rs shifted left by pos. Every other bit of the result comes from rt.
- R4: The insert returns rt unchanged when size is zero or when pos+size is greater than 32, that is, when the top bit of the field would lie above bit 31.
- R5: Code 0x02 copies immediate bits 7:0 (instruction bits 23:16) into all four bytes of the result.
- R6: Code 0x03 copies bits 7:0 of rt into all four bytes of the result.
- R7: Code 0x0A sign-extends the 10-bit immediate to 16 bits and places that value in both halfwords.
- R8: Code 0x0B copies bits 15:0 of rt into both halfwords.
- R9: Any other code with valid high sets `res_illegal` for one cycle, keeps `res_we` low and leaves `res_data` unchanged.
- R10: A recognised code with destination index 0 keeps `res_we` low and `res_illegal` low, and leaves `res_data` unchanged.
- R11: The outputs appear one clock after the valid strobe. A cycle in which valid is low gives `res_we` and `res_illegal` low on the next cycle and leaves `res_data` unchanged.
- R12: `res_we` and `res_illegal` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 5 | Minor operation code |
| src_s | input | 32 | rs operand value |
| src_t | input | 32 | rt operand value |
| imm_field | input | 10 | Instruction bits 25:16 |
| dest_idx | input | 5 | Destination register index |
| dsp_ctrl | input | 32 | DSP control word (insert position and size) |
| res_data | output | 32 | Registered result |
| res_we | output | 1 | Register write enable |
| res_illegal | output | 1 | Reserved-instruction flag |

## Verification
The unit has a single register stage, so every result, write enable and reserved flag is due on the first rising edge after the strobe. The bench drives each operation on a falling edge and lets one rising edge pass. Shortly after that edge it advances its model by that one operation and compares all three outputs. It does this on every clock, including idle cycles, so an output that arrives early, arrives late or is held wrongly shows up as a mismatch in that cycle.

// File: rtl/bitmanip_exec.sv
module bitmanip_exec #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [4:0]   op_code,
  input  logic [W-1:0] src_s,
  input  logic [W-1:0] src_t,
  input  logic [9:0]   imm_field,
  input  logic [4:0]   dest_idx,
  input  logic [W-1:0] dsp_ctrl,
  output logic [W-1:0] res_data,
  output logic         res_we,
  output logic         res_illegal
);
  localparam int HW = W / 2;
  localparam logic [4:0] OP_REV = 5'h1B, OP_INS = 5'h0C, OP_RPB_I = 5'h02,
                         OP_RPB_R = 5'h03, OP_RPH_I = 5'h0A, OP_RPH_R = 5'h0B;

  logic [4:0]   pos, len;
  logic [5:0]   fld_end;
  logic         fld_ok, known;
  logic [W-1:0] mask, ins_val, rev_val, half_imm, nxt;

  assign pos     = dsp_ctrl[4:0];
  assign len     = dsp_ctrl[11:7];
  assign fld_end = {1'b0, pos} + {1'b0, len};
  assign fld_ok  = (len != 5'd0) && (fld_end <= 6'd32);
  assign mask    = ~({W{1'b1}} << len) << pos;
  assign ins_val = fld_ok ? (((src_s << pos) & mask) | (src_t & ~mask)) : src_t;

  for (genvar i = 0; i < HW; i++) begin : g_rev
    assign rev_val[i] = src_t[HW-1-i];
  end
  assign rev_val[W-1:HW] = '0;

  assign half_imm = {2{{6{imm_field[9]}}, imm_field}};

  always_comb begin
    known = 1'b1;
    nxt   = '0;
    unique case (op_code)
      OP_REV:   nxt = rev_val;
      OP_INS:   nxt = ins_val;
      OP_RPB_I: nxt = {4{imm_field[7:0]}};
      OP_RPB_R: nxt = {4{src_t[7:0]}};
      OP_RPH_I: nxt = half_imm;
      OP_RPH_R: nxt = {2{src_t[15:0]}};
      default:  known = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_data    <= '0;
      res_we      <= 1'b0;
      res_illegal <= 1'b0;
    end else begin
      res_we      <= op_valid && known && (dest_idx != 5'd0);
      res_illegal <= op_valid && !known;
      if (op_valid && known && (dest_idx != 5'd0)) res_data <= nxt;
    end
  end
endmodule

module bitmanip_exec_chk (
  input logic        clk,
  input logic        rst,
  input logic        op_valid,
  input logic [4:0]  dest_idx,
  input logic [31:0] res_data,
  input logic        res_we,
  input logic        res_illegal
);
  assert_excl_R12: assert property (@(posedge clk) disable iff (rst)
    !(res_we && res_illegal));
  assert_we_needs_valid_R11: assert property (@(posedge clk) disable iff (rst)
    res_we |-> $past(op_valid));
  assert_we_nonzero_dest_R10: assert property (@(posedge clk) disable iff (rst)
    res_we |-> $past(dest_idx) != 5'd0);
  assert_illegal_needs_valid_R9: assert property (@(posedge clk) disable iff (rst)
    res_illegal |-> $past(op_valid));
  assert_idle_holds_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(op_valid)) |-> $stable(res_data));
endmodule

bind bitmanip_exec bitmanip_exec_chk u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .dest_idx(dest_idx),
  .res_data(res_data), .res_we(res_we), .res_illegal(res_illegal)
);

// File: tb/bitmanip_exec_test.sv
`timescale 1ns/1ps
module bitmanip_exec_test;
  logic        clk = 0, rst = 1, op_valid = 0;
  logic [4:0]  op_code = 0, dest_idx = 0;
  logic [31:0] src_s = 0, src_t = 0, dsp_ctrl = 0;
  logic [9:0]  imm_field = 0;
  logic [31:0] res_data;
  logic        res_we, res_illegal;
  int compared = 0, mismatched = 0;
  logic [31:0] m_data = 0;
  logic m_we = 0, m_ill = 0;

  always #2.5 clk = ~clk;

  bitmanip_exec uut (.clk, .rst, .op_valid, .op_code, .src_s, .src_t,
    .imm_field, .dest_idx, .dsp_ctrl, .res_data, .res_we, .res_illegal);

  function automatic bit is_known(input logic [4:0] c);
    return c inside {5'h1B, 5'h0C, 5'h02, 5'h03, 5'h0A, 5'h0B};
  endfunction

  function automatic logic [31:0] model(input logic [4:0] c, input logic [31:0] s,
      input logic [31:0] t, input logic [9:0] im, input logic [31:0] ctl);
    logic [31:0] r;
    int p, n;
    r = 0;
    case (c)
      5'h1B: for (int i = 0; i < 16; i++) r[15-i] = t[i];
      5'h0C: begin
        p = int'(ctl[4:0]); n = int'(ctl[11:7]);
        r = t;
        if (n != 0 && p + n <= 32)
          for (int i = 0; i < n; i++) r[p+i] = s[i];
      end
      5'h02: for (int b = 0; b < 4; b++) r[b*8 +: 8] = im[7:0];
      5'h03: for (int b = 0; b < 4; b++) r[b*8 +: 8] = t[7:0];
      5'h0A: begin
        int v;
        v = int'(im);
        if (v >= 512) v = v - 1024;
        r = {2{16'(v)}};
      end
      5'h0B: r = {2{t[15:0]}};
      default: r = 0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic v, input logic [4:0] c,
      input logic [4:0] d, input logic [31:0] ctl);
    if (!v) return "R11";
    if (!is_known(c)) return "R9";
    if (d == 0) return "R10";
    case (c)
      5'h1B: return "R2";
      5'h0C: return (ctl[11:7] == 0 || int'(ctl[4:0]) + int'(ctl[11:7]) > 32) ? "R4" : "R3";
      5'h02: return "R5";
      5'h03: return "R6";
      5'h0A: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag);
    compared++;
    if (res_data !== m_data || res_we !== m_we || res_illegal !== m_ill) begin
      mismatched++;
      $display("FAIL %s: got data=%h we=%b ill=%b, expected data=%h we=%b ill=%b",
               tag, res_data, res_we, res_illegal, m_data, m_we, m_ill);
    end
  endtask

  task automatic step(input logic v, input logic [4:0] c, input logic [31:0] s,
      input logic [31:0] t, input logic [9:0] im, input logic [4:0] d,
      input logic [31:0] ctl);
    string tag;
    @(negedge clk);
    op_valid = v; op_code = c; src_s = s; src_t = t; imm_field = im;
    dest_idx = d; dsp_ctrl = ctl;
    tag = tag_of(v, c, d, ctl);
    @(posedge clk); #1;
    m_we  = v && is_known(c) && d != 0;
    m_ill = v && !is_known(c);
    if (m_we) m_data = model(c, s, t, im, ctl);
    check(tag);
  endtask

  function automatic logic [31:0] ctl_of(input int p, input int n);
    logic [31:0] x;
    x = 32'hFFFF_F060;
    x[4:0] = 5'(p); x[11:7] = 5'(n);
    return x;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1");
    @(negedge clk) rst = 0;
    step(1, 5'h1B, 0, 32'hABCD_0001, 0, 3, 0);
    step(1, 5'h1B, 0, 32'h1234_8000, 0, 3, 0);
    step(1, 5'h0C, 32'h0000_002D, 32'hFFFF_FFFF, 0, 4, ctl_of(4, 6));
    step(1, 5'h0C, 32'hFFFF_FFFF, 32'h0, 0, 4, ctl_of(0, 31));
    step(1, 5'h0C, 32'h1, 32'h0, 0, 4, ctl_of(31, 1));
    step(1, 5'h0C, 32'h5555_5555, 32'hA5A5_A5A5, 0, 4, ctl_of(0, 0));
    step(1, 5'h0C, 32'hFFFF_FFFF, 32'h1357_9BDF, 0, 4, ctl_of(30, 3));
    step(1, 5'h0C, 32'hFFFF_FFFF, 32'h1357_9BDF, 0, 4, ctl_of(16, 17));
    step(1, 5'h02, 0, 0, 10'h3C5, 7, 0);
    step(1, 5'h03, 0, 32'h1234_5678, 0, 7, 0);
    step(1, 5'h0A, 0, 0, 10'h200, 8, 0);
    step(1, 5'h0A, 0, 0, 10'h1FF, 8, 0);
    step(1, 5'h0B, 0, 32'hDEAD_BEEF, 0, 8, 0);
    step(1, 5'h1F, 32'h1, 32'h2, 10'h3, 9, 0);
    step(1, 5'h00, 32'h1, 32'h2, 10'h3, 0, 0);
    step(1, 5'h03, 0, 32'h0000_00EE, 0, 0, 0);
    step(0, 5'h03, 0, 32'h0000_0011, 0, 5, 0);
    step(1, 5'h0B, 0, 32'h0000_7777, 0, 5, 0);
    for (int k = 0; k < 400; k++) begin
      logic [4:0] c;
      c = (k % 7 == 6) ? 5'($urandom) :
          (k % 7 == 0) ? 5'h1B : (k % 7 == 1) ? 5'h0C : (k % 7 == 2) ? 5'h02 :
          (k % 7 == 3) ? 5'h03 : (k % 7 == 4) ? 5'h0A : 5'h0B;
      step(($urandom % 8) != 0, c, $urandom, $urandom, 10'($urandom),
           5'($urandom % 5), $urandom);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #100000;
    mismatched++;
    $display("FAIL R11: watchdog expired, got running, expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule